// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Two SRAM Core

This block is a synthesizable model of a pipelined SRAM with a read data port and a write data port that work side by side. The two ports share one address bus. Each read or write command moves two words: an even word and the odd word next to it. The model runs from one system clock at twice the command rate. A phase register marks which cycles stand for the positive input-clock edge (the "K cycle", when `kPhase` is high) and which stand for the complementary edge (the "K# cycle", when `kPhase` is low). Every input is sampled at the rising clock edge that ends its cycle.

In a K cycle the block takes the active-low read and write requests, the read pair address, and the first write word with its byte-lane enables. In the K# cycle that follows, it takes the write pair address and the second write word with its own lane enables. Both write words are stored at the end of that K# cycle, so writes add no latency. A read returns its two words on consecutive cycles after a fixed pipeline delay, and `rdOe` marks the cycles in which the read bus is driven. The `outClkTied` mode input picks one of two read timings: timing from the input clock, or timing from an output clock that is modelled as one extra cycle of delay.

A read sees every write whose command was issued in the same K cycle or earlier. A write issued in the same K cycle as a read to the same pair is forwarded to the read port, so neither port ever stalls.

Top module: `qdrb2_sram`

## Requirements
- R1: While `rstN` is low, and in the cycle after a reset edge, `rdOe` is low and `rdData` is zero.
- R2: `kPhase` is high in the first cycle after reset is released and then toggles every cycle. A write command (`writeN` low in a K cycle) stores that cycle's `wrData` at word 2P and the next K# cycle's `wrData` at word 2P+1, where P is the `addr` value in the K# cycle. A read takes its pair address from `addr` in the K cycle.
- R3: Bit i of `byteWeN` (active low) gates lane i, which is `wrData[9i+8:9i]`, separately for each of the two write words. A lane whose bit is high keeps its old content.
- R4: With `outClkTied` = 1, a read issued in K cycle n drives word 2P during cycle n+2 and word 2P+1 during cycle n+3, with `rdOe` high in both cycles.
- R5: With `outClkTied` = 0, the same read drives word 2P during cycle n+3 and word 2P+1 during cycle n+4, with `rdOe` high in both cycles.
- R6: Reads issued in consecutive K cycles give an unbroken output stream: `rdOe` stays high and one word comes out every cycle.
- R7: Once a burst has finished and no new read follows, `rdOe` goes low in the next cycle and `rdData` reads zero.
- R8: A read and a write issued in the same K cycle are both carried out, each on its own port.
- R9: A read returns the data of every write issued in the same K cycle or earlier. This includes a write to the same pair in the same K cycle, with its lane masks applied. A write issued after the read does not change the data that read returns.
- R10: `readN` and `writeN` are ignored in K# cycles. A low level there starts no read burst and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the command rate |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Read pair address in K cycles, write pair address in K# cycles |
| readN | input | 1 | Read request, active low, sampled in K cycles |
| writeN | input | 1 | Write request, active low, sampled in K cycles |
| wrData | input | 9*LANES | Write word: first word in the K cycle, second word in the K# cycle |
| byteWeN | input | LANES | Lane write enables for the current write word, active low |
| outClkTied | input | 1 | 1: read timing from the input clock; 0: from the output clock |
| kPhase | output | 1 | High in K cycles, low in K# cycles |
| rdData | output | 9*LANES | Read word; zero while the bus is not driven |
| rdOe | output | 1 | Read output enable (low means high impedance) |

## Verification
The bench first fills the whole array with full-lane writes and then reads it back. It does this with isolated reads and with reads back to back. This separates a wrong latency or a broken stream from a wrong burst order. Writes with mixed lane masks, different for each beat, show whether the masks are applied per beat and per lane. Reads and writes to the same pair in one K cycle, and a write issued just after a read of that pair, tell correct forwarding apart from stale data and from data taken too early. Requests pulled low only in K# cycles, and the same traffic run in both timing modes, confirm that the phase decode and the output-clock delay are right.

// File: rtl/qdrb2_pkg.sv
package qdrb2_pkg;

  localparam int LANE_W = 9;

  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic wrCapLo;   // K cycle with write: hold first word and its lane mask
    logic wrCommit;  // K# cycle of a write burst: store both words
    logic rdLoad;    // a read beat is fetched this cycle
    logic rdBeat;    // burst counter low bit for the fetched beat
  } qdr_strobe_t;

endpackage

// File: rtl/qdrb2_ctrl.sv
module qdrb2_ctrl
  import qdrb2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              outClkTied,
  output logic              kPhase,
  output qdr_strobe_t       stb,
  output logic [ADDR_W-1:0] rdPair,
  output logic              rdOe
);

  logic              kPhaseQ;
  logic              rdPend;     // read accepted at the last K edge
  logic              wrPend;     // write accepted at the last K edge
  logic              beatOnePend;
  logic [ADDR_W-1:0] rdPairQ;
  logic              validIn;    // input-clock timed output valid
  logic              validOut;   // output-clock timed output valid

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kPhaseQ     <= 1'b1;
      rdPend      <= 1'b0;
      wrPend      <= 1'b0;
      beatOnePend <= 1'b0;
      rdPairQ     <= '0;
    end else begin
      kPhaseQ     <= ~kPhaseQ;
      beatOnePend <= ~kPhaseQ & rdPend;
      if (kPhaseQ) begin
        rdPend <= ~readN;
        wrPend <= ~writeN;
        if (!readN) rdPairQ <= addr;
      end else begin
        rdPend <= 1'b0;
        wrPend <= 1'b0;
      end
    end
  end

  // Burst counter: beat 0 fetched in the K# cycle, beat 1 in the next K cycle
  always_comb begin
    stb.wrCapLo  = kPhaseQ & ~writeN;
    stb.wrCommit = ~kPhaseQ & wrPend;
    stb.rdLoad   = (~kPhaseQ & rdPend) | beatOnePend;
    stb.rdBeat   = beatOnePend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validIn  <= 1'b0;
      validOut <= 1'b0;
    end else begin
      validIn  <= stb.rdLoad;
      validOut <= validIn;
    end
  end

  assign kPhase = kPhaseQ;
  assign rdPair = rdPairQ;
  assign rdOe   = outClkTied ? validIn : validOut;

endmodule

// File: rtl/qdrb2_datapath.sv
module qdrb2_datapath
  import qdrb2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  qdr_strobe_t             stb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-1:0]       rdPair,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    outClkTied,
  input  logic                    rdOe,
  output logic [LANES*LANE_W-1:0] rdData
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int IDX_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] loWordQ;
  logic [LANES-1:0]  loMaskQ;
  logic [IDX_W-1:0]  wrIdx0, wrIdx1, rdIdx;
  logic [DATA_W-1:0] old0, old1, new0, new1;
  logic [DATA_W-1:0] fetchWord;
  logic [DATA_W-1:0] stageIn, stageOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loWordQ <= '0;
      loMaskQ <= '1;
    end else if (stb.wrCapLo) begin
      loWordQ <= wrData;
      loMaskQ <= byteWeN;
    end
  end

  assign wrIdx0 = {addr, 1'b0};
  assign wrIdx1 = {addr, 1'b1};
  assign old0   = mem[wrIdx0];
  assign old1   = mem[wrIdx1];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign new0[i*LANE_W +: LANE_W] = loMaskQ[i] ? old0[i*LANE_W +: LANE_W]
                                                 : loWordQ[i*LANE_W +: LANE_W];
    assign new1[i*LANE_W +: LANE_W] = byteWeN[i] ? old1[i*LANE_W +: LANE_W]
                                                 : wrData[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (stb.wrCommit) begin
      mem[wrIdx0] <= new0;
      mem[wrIdx1] <= new1;
    end
  end

  // Fetch with forwarding from the burst being stored this cycle
  assign rdIdx = {rdPair, stb.rdBeat};

  always_comb begin
    fetchWord = mem[rdIdx];
    if (stb.wrCommit) begin
      if (rdIdx == wrIdx0)      fetchWord = new0;
      else if (rdIdx == wrIdx1) fetchWord = new1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageIn  <= '0;
      stageOut <= '0;
    end else begin
      if (stb.rdLoad) stageIn <= fetchWord;
      stageOut <= stageIn;
    end
  end

  assign rdData = rdOe ? (outClkTied ? stageIn : stageOut) : '0;

endmodule

// File: rtl/qdrb2_sram.sv
module qdrb2_sram
  import qdrb2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    readN,
  input  logic                    writeN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    outClkTied,
  output logic                    kPhase,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdOe
);

  qdr_strobe_t       stb;
  logic [ADDR_W-1:0] rdPair;

  qdrb2_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .readN     (readN),
    .writeN    (writeN),
    .addr      (addr),
    .outClkTied(outClkTied),
    .kPhase    (kPhase),
    .stb       (stb),
    .rdPair    (rdPair),
    .rdOe      (rdOe)
  );

  qdrb2_datapath #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addr      (addr),
    .rdPair    (rdPair),
    .wrData    (wrData),
    .byteWeN   (byteWeN),
    .outClkTied(outClkTied),
    .rdOe      (rdOe),
    .rdData    (rdData)
  );

endmodule

// File: rtl/qdrb2_chk.sv
module qdrb2_chk (
  input logic clk,
  input logic rstN,
  input logic readN,
  input logic kPhase,
  input logic outClkTied,
  input logic rdOe
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !rdOe);

  // R2
  phase_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    kPhase |=> !kPhase);

  // R2
  phase_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !kPhase |=> kPhase);

  // R4
  tied_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outClkTied && $past(outClkTied) && rdOe) |->
      ($past(kPhase && !readN, 2) || $past(kPhase && !readN, 3)));

  // R5
  lagged_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outClkTied && !$past(outClkTied) && rdOe) |->
      ($past(kPhase && !readN, 3) || $past(kPhase && !readN, 4)));

  // R6
  tied_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outClkTied && $past(outClkTied, 2) && $past(rstN, 2) &&
     $past(kPhase && !readN, 2)) |-> rdOe);

  // R6
  lagged_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outClkTied && !$past(outClkTied, 3) && $past(rstN, 3) &&
     $past(kPhase && !readN, 3)) |-> rdOe);

endmodule

bind qdrb2_sram qdrb2_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .readN     (readN),
  .kPhase    (kPhase),
  .outClkTied(outClkTied),
  .rdOe      (rdOe)
);

// File: tb/qdrb2_sram_bench.sv
module qdrb2_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int LANES = 4;
  localparam int DW    = LANES * 9;
  localparam int PAIRS = 1 << AW;
  localparam int WORDS = 2 * PAIRS;
  localparam int SLOTS = 256;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          readN, writeN;
  logic [DW-1:0] wrData;
  logic [LANES-1:0] byteWeN;
  logic          outClkTied;
  logic          kPhase;
  logic [DW-1:0] rdData;
  logic          rdOe;

  qdrb2_sram #(.ADDR_W(AW), .LANES(LANES)) u_qdrb2_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .readN(readN), .writeN(writeN),
    .wrData(wrData), .byteWeN(byteWeN), .outClkTied(outClkTied),
    .kPhase(kPhase), .rdData(rdData), .rdOe(rdOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference state
  logic [DW-1:0] refMem [WORDS];
  logic          expOe   [SLOTS];
  logic [DW-1:0] expData [SLOTS];
  string         expTag  [SLOTS];
  string         curTag = "R7";
  bit            checking = 1'b0;
  bit            finished = 1'b0;
  int            nChecks = 0;
  int            nFails  = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    end
  endtask

  // Per-cycle comparison against the expected output stream
  int    slotNow;
  string slotTag;
  always @(negedge clk) begin
    if (checking) begin
      slotNow = cyc % SLOTS;
      slotTag = expOe[slotNow] ? expTag[slotNow] : curTag;
      chk(slotTag, "rdOe", {63'd0, rdOe}, {63'd0, expOe[slotNow]});
      chk(slotTag, "rdData", {{(64-DW){1'b0}}, rdData}, {{(64-DW){1'b0}}, expData[slotNow]});
      expOe[slotNow]   = 1'b0;
      expData[slotNow] = '0;
    end
  end

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  task automatic refWrite(int idx, logic [DW-1:0] d, logic [LANES-1:0] beN);
    for (int i = 0; i < LANES; i++)
      if (!beN[i]) refMem[idx][i*9 +: 9] = d[i*9 +: 9];
  endtask

  // Drives one K cycle and one K# cycle; entered and left at a K-cycle negedge
  task automatic doPair(bit rd, int rp, bit wr, int wp,
                        logic [DW-1:0] d0, logic [LANES-1:0] be0,
                        logic [DW-1:0] d1, logic [LANES-1:0] be1,
                        string tag, bit junk = 1'b0);
    int lat;
    chk("R2", "kPhase in K cycle", {63'd0, kPhase}, 64'd1);
    readN   = !rd;
    writeN  = !wr;
    addr    = rp[AW-1:0];
    wrData  = d0;
    byteWeN = be0;
    if (wr) begin
      refWrite(2*wp,     d0, be0);
      refWrite(2*wp + 1, d1, be1);
    end
    if (rd) begin
      lat = outClkTied ? 2 : 3;
      expOe[(cyc+lat) % SLOTS]     = 1'b1;
      expData[(cyc+lat) % SLOTS]   = refMem[2*rp];
      expTag[(cyc+lat) % SLOTS]    = tag;
      expOe[(cyc+lat+1) % SLOTS]   = 1'b1;
      expData[(cyc+lat+1) % SLOTS] = refMem[2*rp + 1];
      expTag[(cyc+lat+1) % SLOTS]  = tag;
    end
    @(negedge clk);
    chk("R2", "kPhase in K# cycle", {63'd0, kPhase}, 64'd0);
    addr    = wp[AW-1:0];
    wrData  = d1;
    byteWeN = be1;
    readN   = !junk;
    writeN  = !junk;
    @(negedge clk);
  endtask

  task automatic idlePairs(int n);
    for (int k = 0; k < n; k++)
      doPair(1'b0, 0, 1'b0, 0, '0, '1, '0, '1, curTag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      expOe[s] = 1'b0; expData[s] = '0; expTag[s] = "R7";
    end
    for (int w = 0; w < WORDS; w++) refMem[w] = '0;
    rstN = 1'b0; readN = 1'b1; writeN = 1'b1; addr = '0;
    wrData = '0; byteWeN = '1; outClkTied = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet outputs in reset
    chk("R1", "rdOe in reset", {63'd0, rdOe}, 64'd0);
    chk("R1", "rdData in reset", {{(64-DW){1'b0}}, rdData}, 64'd0);
    rstN = 1'b1;
    checking = 1'b1;

    // R2: fill the array with full-lane writes
    curTag = "R2";
    for (int p = 0; p < PAIRS; p++) doPair(1'b0, 0, 1'b1, p, rnd(), '0, rnd(), '0, "R2");
    idlePairs(2);

    // R4: one isolated read, input-clock timing
    curTag = "R7";
    doPair(1'b1, 3, 1'b0, 0, '0, '1, '0, '1, "R4");
    idlePairs(3);

    // R6: back-to-back reads across the array
    for (int p = 0; p < PAIRS; p++) doPair(1'b1, p, 1'b0, 0, '0, '1, '0, '1, "R6");
    idlePairs(3);

    // R3: lane-masked writes, then read back
    curTag = "R3";
    for (int p = 0; p < 8; p++) begin
      logic [LANES-1:0] m;
      m = LANES'(p * 5 + 3);
      doPair(1'b0, 0, 1'b1, p, rnd(), m, rnd(), ~m, "R3");
    end
    doPair(1'b0, 0, 1'b1, 9, rnd(), '1, rnd(), '1, "R3");
    for (int p = 0; p < 10; p++) doPair(1'b1, p, 1'b0, 0, '0, '1, '0, '1, "R3");
    idlePairs(3);

    // R8: simultaneous read and write on different pairs
    curTag = "R8";
    for (int p = 0; p < 6; p++)
      doPair(1'b1, p, 1'b1, p + 8, '0, '1, '0, '1, "R8");
    for (int p = 0; p < 6; p++)
      doPair(1'b1, p + 8, 1'b1, p, rnd(), 4'b0101, rnd(), 4'b1000, "R8");
    idlePairs(2);
    for (int p = 0; p < 6; p++) doPair(1'b1, p, 1'b0, 0, '0, '1, '0, '1, "R8");
    idlePairs(3);

    // R9: same-pair read and write in one K cycle, then write just after a read
    curTag = "R9";
    doPair(1'b1, 4, 1'b1, 4, rnd(), 4'b0110, rnd(), 4'b1001, "R9");
    doPair(1'b1, 4, 1'b0, 0, '0, '1, '0, '1, "R9");
    doPair(1'b1, 7, 1'b1, 7, rnd(), 4'b0000, rnd(), 4'b0000, "R9");
    doPair(1'b1, 2, 1'b0, 0, '0, '1, '0, '1, "R9");
    doPair(1'b0, 0, 1'b1, 2, rnd(), 4'b0000, rnd(), 4'b0000, "R9");
    doPair(1'b1, 2, 1'b0, 0, '0, '1, '0, '1, "R9");
    idlePairs(3);

    // R5: output-clock timing, isolated then streaming
    outClkTied = 1'b0;
    curTag = "R5";
    doPair(1'b1, 5, 1'b0, 0, '0, '1, '0, '1, "R5");
    idlePairs(3);
    for (int p = 0; p < 6; p++) doPair(1'b1, p + 3, 1'b0, 0, '0, '1, '0, '1, "R6");
    doPair(1'b1, 11, 1'b1, 11, rnd(), 4'b1100, rnd(), 4'b0011, "R9");
    idlePairs(4);
    outClkTied = 1'b1;
    idlePairs(2);

    // R7: reads with one idle pair between, deselect each time
    curTag = "R7";
    for (int p = 0; p < 4; p++) begin
      doPair(1'b1, p + 12, 1'b0, 0, '0, '1, '0, '1, "R7");
      idlePairs(1);
    end
    idlePairs(2);

    // R10: requests low only in K# cycles must do nothing
    curTag = "R10";
    doPair(1'b0, 0, 1'b0, 5, rnd(), '0, rnd(), '0, "R10", 1'b1);
    doPair(1'b0, 0, 1'b0, 6, rnd(), '0, rnd(), '0, "R10", 1'b1);
    idlePairs(3);
    doPair(1'b1, 5, 1'b0, 0, '0, '1, '0, '1, "R10");
    doPair(1'b1, 6, 1'b0, 0, '0, '1, '0, '1, "R10");
    idlePairs(4);

    checking = 1'b0;
    summary();
    $finish;
  end

endmodule